// File: doc/BRIEF.md
# Flash Protection Command Sequencer

This block decodes the write cycles of a byte-wide parallel NOR flash model. It handles the sector-protection command sets only. Each bus write (address, data byte, one-cycle write strobe) is checked against a three-cycle unlock-and-entry sequence. A completed entry selects one of five protection command sets: lock register, password, persistent protection, persistent-protection freeze, or dynamic protection. The block then stays in that set. Every later write and read is interpreted inside the set until a two-cycle exit sequence returns the part to array reading.

Inside a set the block decodes program, erase and status-read requests. It holds one dynamic protection bit and one persistent protection bit per sector, plus a freeze flag, a lock register byte and an eight-byte password. Reads are combinational. In a set they return a status byte or register contents. In array mode they flag that the read belongs to the memory array. The sector is the address field from the top bit down to bit 16, so the sector count follows from the address width.

Top module: `flash_prot_seq`

## Requirements
- R1: An entry sequence is three writes: data AA at address 0AAA, then 55 at 0555, then a set code at 0AAA. Only address bits [15:0] and data bits [7:0] are compared; the address bits above 15 and data bits [15:8] are ignored.
- R2: The third-cycle code selects the set: E0 dynamic, C0 persistent, 50 freeze, 40 lock register, 60 password. Any other code leaves the block in array mode (rd_array stays 1); a valid code clears rd_array.
- R3: A first or second unlock write whose address or data differs from the expected value abandons the partial sequence, and the mode stays array read.
- R4: Inside a set, only a write of data 90 followed by a write of data 00 (any address) returns to array mode. Unlock-like writes do not leave the set, and a 90 followed by other data abandons the exit. Protection bits keep their values across the exit.
- R5: In the dynamic set, a write of A0 followed by a write of 00 sets prot_dyn[s] to 1 (protected), and A0 followed by 01 clears it. The sector s is the second write's address bits [ADDR_W-1:16]. A0 followed by any other data changes nothing.
- R6: In the dynamic and persistent sets, a read returns 00 when the bit for the sector at rd_addr[ADDR_W-1:16] is 1 (protected) and 01 otherwise. In the freeze set it returns 00 when frozen and 01 otherwise.
- R7: After reset all protection bits are 0, the freeze flag is clear, the lock register reads FF, all password bytes read FF and the mode is array read.
- R8: In array mode, program and erase writes (A0, 80, 30, 00 and others) change no protection bit.
- R9: In the persistent set, A0 followed by 00 sets prot_ppb[s]. A write of 80 followed by a write of 30 clears every persistent bit in one step. 80 followed by any other data changes nothing.
- R10: In the freeze set, A0 followed by 00 sets the freeze flag. The flag stays set until reset, and while it is set persistent program and erase have no effect.
- R11: In the lock-register set, A0 followed by data D sets the register to its old value AND D, and a read returns the register. If D has both bit 1 and bit 2 at 0, the register is unchanged and the block returns to array mode.
- R12: In the password set, A0 followed by data D at an address with byte index i = address[2:0] sets password byte i to its old value AND D. A read returns byte rd_addr[2:0].
- R13: In array mode rd_array is 1 and rd_data is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle strobe marking a bus write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 16 | Write data; bits [15:8] ignored |
| rd_addr | input | ADDR_W | Read address (sector field and byte index) |
| rd_data | output | 8 | Status byte or register contents for the current set |
| rd_array | output | 1 | 1 when reads belong to the memory array |
| prot_dyn | output | 2**(ADDR_W-16) | Dynamic protection bit per sector, 1 = protected |
| prot_ppb | output | 2**(ADDR_W-16) | Persistent protection bit per sector, 1 = protected |

## Verification
The assertions assume that each bus write is a single-cycle wr_en pulse and that its address and data are stable at the sampling edge. They also assume that rd_addr is stable whenever rd_data is sampled. The stimulus drives every write at the falling edge, holds it for exactly one cycle and follows it with an idle cycle. It changes rd_addr only on idle cycles and samples a short delay later. Unlock writes carry changing junk in the ignored address and data bits. This shows that those bits have no effect, without breaking the one-write-per-strobe assumption.

// File: rtl/fps_pkg.sv
package fps_pkg;

    // command-set modes
    typedef enum logic [2:0] {
        M_ARRAY   = 3'd0,
        M_LOCKREG = 3'd1,
        M_PWD     = 3'd2,
        M_PPB     = 3'd3,
        M_PPBLK   = 3'd4,
        M_DYB     = 3'd5
    } mode_e;

    // position inside a multi-cycle sequence
    typedef enum logic [2:0] {
        P_IDLE = 3'd0,
        P_UNL1 = 3'd1,
        P_UNL2 = 3'd2,
        P_EXIT = 3'd3,
        P_PGM  = 3'd4,
        P_ERA  = 3'd5
    } phase_e;

    localparam int SECT_LSB   = 16;
    localparam int PWD_BYTES  = 8;
    localparam int PWD_IDX_W  = $clog2(PWD_BYTES);

    localparam logic [15:0] UNL_ADDR_A = 16'h0AAA;
    localparam logic [15:0] UNL_ADDR_B = 16'h0555;
    localparam logic [7:0]  UNL_DATA_A = 8'hAA;
    localparam logic [7:0]  UNL_DATA_B = 8'h55;

    localparam logic [7:0]  CODE_LOCKREG = 8'h40;
    localparam logic [7:0]  CODE_PWD     = 8'h60;
    localparam logic [7:0]  CODE_PPB     = 8'hC0;
    localparam logic [7:0]  CODE_PPBLK   = 8'h50;
    localparam logic [7:0]  CODE_DYB     = 8'hE0;

    localparam logic [7:0]  CMD_EXIT_A   = 8'h90;
    localparam logic [7:0]  CMD_EXIT_B   = 8'h00;
    localparam logic [7:0]  CMD_PGM      = 8'hA0;
    localparam logic [7:0]  CMD_ERA_SET  = 8'h80;
    localparam logic [7:0]  CMD_ERA_GO   = 8'h30;
    localparam logic [7:0]  ARG_SET      = 8'h00;
    localparam logic [7:0]  ARG_CLR      = 8'h01;

    localparam logic [7:0]  STAT_PROT    = 8'h00;
    localparam logic [7:0]  STAT_OPEN    = 8'h01;

    // one-cycle update strobes produced by the sequencer
    typedef struct packed {
        logic                 dyb_set;
        logic                 dyb_clr;
        logic                 ppb_pgm;
        logic                 ppb_erase;
        logic                 freeze;
        logic                 lock_pgm;
        logic                 pwd_pgm;
        logic [7:0]           data;
        logic [PWD_IDX_W-1:0] byte_idx;
    } act_t;

    function automatic mode_e code_to_mode(input logic [7:0] code);
        case (code)
            CODE_LOCKREG: return M_LOCKREG;
            CODE_PWD:     return M_PWD;
            CODE_PPB:     return M_PPB;
            CODE_PPBLK:   return M_PPBLK;
            CODE_DYB:     return M_DYB;
            default:      return M_ARRAY;
        endcase
    endfunction

    function automatic logic [7:0] stat_byte(input logic prot);
        return prot ? STAT_PROT : STAT_OPEN;
    endfunction

    // both mode-lock bits written to zero in one program: rejected
    function automatic logic lock_pgm_rejected(input logic [7:0] d);
        return ~d[1] & ~d[2];
    endfunction

endpackage

// File: rtl/fps_seq.sv
module fps_seq
    import fps_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [15:0] wr_lo_addr,
    input  logic [7:0]  wr_byte,
    output mode_e       mode_o,
    output phase_e      phase_o,
    output act_t        act_o
);

    mode_e  mode_q,  mode_d;
    phase_e phase_q, phase_d;
    act_t   act;

    always_comb begin
        mode_d       = mode_q;
        phase_d      = phase_q;
        act          = '0;
        act.data     = wr_byte;
        act.byte_idx = wr_lo_addr[PWD_IDX_W-1:0];
        if (wr_en) begin
            if (mode_q == M_ARRAY) begin
                case (phase_q)
                    P_UNL1: begin
                        if (wr_lo_addr == UNL_ADDR_B && wr_byte == UNL_DATA_B)
                            phase_d = P_UNL2;
                        else
                            phase_d = P_IDLE;
                    end
                    P_UNL2: begin
                        phase_d = P_IDLE;
                        if (wr_lo_addr == UNL_ADDR_A)
                            mode_d = code_to_mode(wr_byte);
                    end
                    default: begin
                        if (wr_lo_addr == UNL_ADDR_A && wr_byte == UNL_DATA_A)
                            phase_d = P_UNL1;
                        else
                            phase_d = P_IDLE;
                    end
                endcase
            end else begin
                case (phase_q)
                    P_EXIT: begin
                        phase_d = P_IDLE;
                        if (wr_byte == CMD_EXIT_B)
                            mode_d = M_ARRAY;
                    end
                    P_PGM: begin
                        phase_d = P_IDLE;
                        case (mode_q)
                            M_DYB: begin
                                act.dyb_set = (wr_byte == ARG_SET);
                                act.dyb_clr = (wr_byte == ARG_CLR);
                            end
                            M_PPB:   act.ppb_pgm = (wr_byte == ARG_SET);
                            M_PPBLK: act.freeze  = (wr_byte == ARG_SET);
                            M_LOCKREG: begin
                                if (lock_pgm_rejected(wr_byte))
                                    mode_d = M_ARRAY;
                                else
                                    act.lock_pgm = 1'b1;
                            end
                            M_PWD:   act.pwd_pgm = 1'b1;
                            default: ;
                        endcase
                    end
                    P_ERA: begin
                        phase_d       = P_IDLE;
                        act.ppb_erase = (wr_byte == CMD_ERA_GO);
                    end
                    default: begin
                        if (wr_byte == CMD_EXIT_A)
                            phase_d = P_EXIT;
                        else if (wr_byte == CMD_PGM)
                            phase_d = P_PGM;
                        else if (wr_byte == CMD_ERA_SET && mode_q == M_PPB)
                            phase_d = P_ERA;
                        else
                            phase_d = P_IDLE;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= M_ARRAY;
            phase_q <= P_IDLE;
        end else begin
            mode_q  <= mode_d;
            phase_q <= phase_d;
        end
    end

    assign mode_o  = mode_q;
    assign phase_o = phase_q;
    assign act_o   = act;

endmodule

// File: rtl/fps_prot_bits.sv
module fps_prot_bits
    import fps_pkg::*;
#(
    parameter  int SECT_W = 4,
    localparam int N_SECT = 1 << SECT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  act_t              act,
    input  logic [SECT_W-1:0] sect,
    input  logic              frozen,
    output logic [N_SECT-1:0] dyb_q,
    output logic [N_SECT-1:0] ppb_q
);

    logic unused_act;
    assign unused_act = ^{act.freeze, act.lock_pgm, act.pwd_pgm, act.data, act.byte_idx};

    for (genvar g = 0; g < N_SECT; g++) begin : g_sect
        logic hit;
        assign hit = (sect == SECT_W'(g));

        always_ff @(posedge clk) begin
            if (rst)
                dyb_q[g] <= 1'b0;
            else if (act.dyb_set && hit)
                dyb_q[g] <= 1'b1;
            else if (act.dyb_clr && hit)
                dyb_q[g] <= 1'b0;
        end

        always_ff @(posedge clk) begin
            if (rst)
                ppb_q[g] <= 1'b0;
            else if (!frozen) begin
                if (act.ppb_erase)
                    ppb_q[g] <= 1'b0;
                else if (act.ppb_pgm && hit)
                    ppb_q[g] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/fps_regs.sv
module fps_regs
    import fps_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  act_t                      act,
    output logic [7:0]                lock_q,
    output logic [PWD_BYTES-1:0][7:0] pwd_q,
    output logic                      frozen_q
);

    logic unused_act;
    assign unused_act = ^{act.dyb_set, act.dyb_clr, act.ppb_pgm, act.ppb_erase};

    always_ff @(posedge clk) begin
        if (rst)
            lock_q <= 8'hFF;
        else if (act.lock_pgm)
            lock_q <= lock_q & act.data;
    end

    always_ff @(posedge clk) begin
        if (rst)
            frozen_q <= 1'b0;
        else if (act.freeze)
            frozen_q <= 1'b1;
    end

    for (genvar g = 0; g < PWD_BYTES; g++) begin : g_pwd
        always_ff @(posedge clk) begin
            if (rst)
                pwd_q[g] <= 8'hFF;
            else if (act.pwd_pgm && act.byte_idx == PWD_IDX_W'(g))
                pwd_q[g] <= pwd_q[g] & act.data;
        end
    end

endmodule

// File: rtl/flash_prot_seq.sv
module flash_prot_seq
    import fps_pkg::*;
#(
    parameter  int ADDR_W = 20,
    localparam int SECT_W = ADDR_W - SECT_LSB,
    localparam int N_SECT = 1 << SECT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [15:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              rd_array,
    output logic [N_SECT-1:0] prot_dyn,
    output logic [N_SECT-1:0] prot_ppb
);

    mode_e                     mode_q;
    phase_e                    phase_q;
    act_t                      act;
    logic [SECT_W-1:0]         wr_sect;
    logic [SECT_W-1:0]         rd_sect;
    logic [7:0]                lock_q;
    logic [PWD_BYTES-1:0][7:0] pwd_q;
    logic                      frozen;
    logic                      unused_bits;

    assign wr_sect     = wr_addr[ADDR_W-1:SECT_LSB];
    assign rd_sect     = rd_addr[ADDR_W-1:SECT_LSB];
    assign unused_bits = ^{wr_data[15:8], rd_addr[SECT_LSB-1:PWD_IDX_W]};

    fps_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_lo_addr (wr_addr[15:0]),
        .wr_byte    (wr_data[7:0]),
        .mode_o     (mode_q),
        .phase_o    (phase_q),
        .act_o      (act)
    );

    fps_prot_bits #(.SECT_W(SECT_W)) u_bits (
        .clk    (clk),
        .rst    (rst),
        .act    (act),
        .sect   (wr_sect),
        .frozen (frozen),
        .dyb_q  (prot_dyn),
        .ppb_q  (prot_ppb)
    );

    fps_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .act      (act),
        .lock_q   (lock_q),
        .pwd_q    (pwd_q),
        .frozen_q (frozen)
    );

    always_comb begin
        case (mode_q)
            M_LOCKREG: rd_data = lock_q;
            M_PWD:     rd_data = pwd_q[rd_addr[PWD_IDX_W-1:0]];
            M_PPB:     rd_data = stat_byte(prot_ppb[rd_sect]);
            M_PPBLK:   rd_data = stat_byte(frozen);
            M_DYB:     rd_data = stat_byte(prot_dyn[rd_sect]);
            default:   rd_data = 8'h00;
        endcase
    end

    assign rd_array = (mode_q == M_ARRAY);

endmodule

// File: rtl/fps_checker.sv
module fps_checker
    import fps_pkg::*;
#(
    parameter int N_SECT = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [7:0]        wr_byte,
    input mode_e             mode,
    input phase_e            phase,
    input logic [7:0]        rd_data,
    input logic [N_SECT-1:0] prot_dyn,
    input logic [N_SECT-1:0] prot_ppb,
    input logic              frozen
);

    // R2: a set is only entered from the third unlock position
    a_r2_entry_needs_unlock: assert property (@(posedge clk) disable iff (rst)
        (mode == M_ARRAY && phase != P_UNL2) |=> (mode == M_ARRAY));

    // R3: wrong second unlock data drops the partial sequence
    a_r3_abort_unlock: assert property (@(posedge clk) disable iff (rst)
        (mode == M_ARRAY && phase == P_UNL1 && wr_en && wr_byte != UNL_DATA_B)
        |=> (mode == M_ARRAY && phase == P_IDLE));

    // R4: the set is kept unless the exit completes or a lock program is rejected
    a_r4_set_sticky: assert property (@(posedge clk) disable iff (rst)
        (mode != M_ARRAY
         && !(wr_en && phase == P_EXIT && wr_byte == CMD_EXIT_B)
         && !(wr_en && phase == P_PGM && mode == M_LOCKREG))
        |=> $stable(mode));

    // R5: at most one dynamic bit changes per cycle
    a_r5_single_dyb_change: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $onehot0(prot_dyn ^ $past(prot_dyn)));

    // R6: status bytes are 00 or 01 only
    a_r6_status_encoding: assert property (@(posedge clk) disable iff (rst)
        (mode == M_DYB || mode == M_PPB || mode == M_PPBLK) |-> (rd_data[7:1] == 7'd0));

    // R8: array mode writes leave all protection bits alone
    a_r8_array_no_update: assert property (@(posedge clk) disable iff (rst)
        (mode == M_ARRAY) |=> ($stable(prot_dyn) && $stable(prot_ppb)));

    // R10: freeze is sticky and holds the persistent bits
    a_r10_freeze_holds: assert property (@(posedge clk) disable iff (rst)
        frozen |=> (frozen && $stable(prot_ppb)));

    // R13: array reads return zero
    a_r13_array_read_zero: assert property (@(posedge clk) disable iff (rst)
        (mode == M_ARRAY) |-> (rd_data == 8'h00));

endmodule

bind flash_prot_seq fps_checker #(.N_SECT(N_SECT)) u_fps_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_byte  (wr_data[7:0]),
    .mode     (mode_q),
    .phase    (phase_q),
    .rd_data  (rd_data),
    .prot_dyn (prot_dyn),
    .prot_ppb (prot_ppb),
    .frozen   (frozen)
);

// File: tb/sim_flash_prot_seq.sv
`timescale 1ns/1ps
module sim_flash_prot_seq;

    localparam int AW = 19;
    localparam int NS = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [15:0]   wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;
    logic          rd_array;
    logic [NS-1:0] prot_dyn;
    logic [NS-1:0] prot_ppb;

    int          tests = 0;
    int          fails = 0;
    bit          done  = 1'b0;
    logic [15:0] junk  = 16'h1234;

    always #2 clk = ~clk;

    flash_prot_seq #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .rd_array(rd_array),
        .prot_dyn(prot_dyn), .prot_ppb(prot_ppb)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        wr_en = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr_raw(input logic [AW-1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // low 16 address bits given, junk in ignored upper bits
    task automatic wr_cmd(input logic [15:0] lo, input logic [7:0] b);
        junk = junk * 16'd5 + 16'd3;
        wr_raw({junk[2:0], lo}, {junk[15:8], b});
    endtask

    task automatic wr_sect(input int s, input logic [7:0] b);
        junk = junk * 16'd5 + 16'd3;
        wr_raw({3'(s), junk}, {junk[15:8], b});
    endtask

    task automatic enter_set(input logic [7:0] code);
        wr_cmd(16'h0AAA, 8'hAA);
        wr_cmd(16'h0555, 8'h55);
        wr_cmd(16'h0AAA, code);
    endtask

    task automatic leave_set();
        wr_cmd(junk, 8'h90);
        wr_cmd(junk, 8'h00);
    endtask

    task automatic rd_at(input logic [AW-1:0] a, output logic [7:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    function automatic logic [7:0] pwd_val(input int i);
        return 8'((i * 37) ^ 8'h5A);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] pat [5];
        pat[0] = 8'hA5; pat[1] = 8'h3C; pat[2] = 8'hFF; pat[3] = 8'h00; pat[4] = 8'h81;

        do_reset();

        // R7 / R13: reset state
        chk("R7 prot_dyn after reset", prot_dyn, 0);
        chk("R7 prot_ppb after reset", prot_ppb, 0);
        chk("R13 rd_array after reset", rd_array, 1);
        for (int s = 0; s < NS; s++) begin
            rd_at({3'(s), 16'h0AAA}, v);
            chk("R13 array read zero", v, 0);
        end

        // R1 / R2: sweep every third-cycle code
        for (int c = 0; c < 256; c++) begin
            bit valid;
            logic [7:0] exp_rd;
            valid = (c == 8'h40 || c == 8'h60 || c == 8'hC0 || c == 8'h50 || c == 8'hE0);
            exp_rd = (c == 8'h40 || c == 8'h60) ? 8'hFF : 8'h01;
            enter_set(8'(c));
            chk($sformatf("R2 R1 rd_array after code %0h", c), rd_array, !valid);
            if (valid) begin
                rd_at({3'd5, 16'h0000}, v);
                chk($sformatf("R2 read in set %0h", c), v, exp_rd);
                leave_set();
                chk("R4 exit to array", rd_array, 1);
            end
        end

        // R3: corrupted unlock cycles
        wr_cmd(16'h0AAB, 8'hAA); wr_cmd(16'h0555, 8'h55); wr_cmd(16'h0AAA, 8'hE0);
        chk("R3 bad first address", rd_array, 1);
        wr_cmd(16'h0AAA, 8'hAB); wr_cmd(16'h0555, 8'h55); wr_cmd(16'h0AAA, 8'hE0);
        chk("R3 bad first data", rd_array, 1);
        wr_cmd(16'h0AAA, 8'hAA); wr_cmd(16'h0555, 8'h56); wr_cmd(16'h0AAA, 8'hE0);
        chk("R3 bad second data", rd_array, 1);
        wr_cmd(16'h0AAA, 8'hAA); wr_cmd(16'h0554, 8'h55); wr_cmd(16'h0AAA, 8'hE0);
        chk("R3 bad second address", rd_array, 1);

        // R1: all ignored bits set
        wr_raw({3'b111, 16'h0AAA}, 16'hFFAA);
        wr_raw({3'b111, 16'h0555}, 16'hFF55);
        wr_raw({3'b111, 16'h0AAA}, 16'hFFE0);
        chk("R1 upper bits ignored", rd_array, 0);

        // R5 / R6: dynamic bits under several patterns
        for (int p = 0; p < 5; p++) begin
            for (int s = 0; s < NS; s++) begin
                wr_cmd(junk, 8'hA0);
                wr_sect(s, pat[p][s] ? 8'h00 : 8'h01);
            end
            chk($sformatf("R5 prot_dyn pattern %0h", pat[p]), prot_dyn, pat[p]);
            for (int s = 0; s < NS; s++) begin
                rd_at({3'(s), 16'h0000}, v);
                chk("R6 dynamic status", v, pat[p][s] ? 8'h00 : 8'h01);
            end
        end
        wr_cmd(junk, 8'hA0); wr_sect(1, 8'h02);
        wr_cmd(junk, 8'hA0); wr_sect(0, 8'h03);
        chk("R5 other argument ignored", prot_dyn, 8'h81);

        // R4: writes inside the set do not leave it
        enter_set(8'h40);
        rd_at({3'd0, 16'h0000}, v);
        chk("R4 unlock inside set ignored", v, 8'h00);
        wr_cmd(junk, 8'h90); wr_cmd(junk, 8'h55);
        chk("R4 broken exit stays", rd_array, 0);
        rd_at({3'd7, 16'h0000}, v);
        chk("R4 still dynamic set", v, 8'h00);
        leave_set();
        chk("R4 exit completes", rd_array, 1);
        chk("R4 bits kept after exit", prot_dyn, 8'h81);

        // R8: program and erase in array mode
        wr_cmd(junk, 8'hA0); wr_sect(2, 8'h00);
        wr_cmd(junk, 8'hA0); wr_sect(0, 8'h01);
        wr_cmd(junk, 8'h80); wr_cmd(junk, 8'h30);
        chk("R8 dyn unchanged in array", prot_dyn, 8'h81);
        chk("R8 ppb unchanged in array", prot_ppb, 8'h00);

        // R9: persistent program and erase
        enter_set(8'hC0);
        wr_cmd(junk, 8'hA0); wr_sect(1, 8'h00);
        wr_cmd(junk, 8'hA0); wr_sect(3, 8'h00);
        wr_cmd(junk, 8'hA0); wr_sect(6, 8'h00);
        chk("R9 ppb program", prot_ppb, 8'h4A);
        for (int s = 0; s < NS; s++) begin
            rd_at({3'(s), 16'h0000}, v);
            chk("R6 persistent status", v, ((8'h4A >> s) & 1) != 0 ? 8'h00 : 8'h01);
        end
        wr_cmd(junk, 8'h80); wr_cmd(junk, 8'h30);
        chk("R9 ppb erase all", prot_ppb, 8'h00);
        wr_cmd(junk, 8'hA0); wr_sect(2, 8'h00);
        wr_cmd(junk, 8'h80); wr_cmd(junk, 8'h31);
        chk("R9 bad erase confirm", prot_ppb, 8'h04);
        leave_set();

        // R10: freeze
        enter_set(8'h50);
        rd_at('0, v);
        chk("R6 freeze status open", v, 8'h01);
        wr_cmd(junk, 8'hA0); wr_cmd(junk, 8'h00);
        rd_at('0, v);
        chk("R10 freeze status set", v, 8'h00);
        leave_set();
        enter_set(8'hC0);
        wr_cmd(junk, 8'hA0); wr_sect(5, 8'h00);
        chk("R10 program blocked", prot_ppb, 8'h04);
        wr_cmd(junk, 8'h80); wr_cmd(junk, 8'h30);
        chk("R10 erase blocked", prot_ppb, 8'h04);
        leave_set();

        // R12: password bytes
        enter_set(8'h60);
        for (int i = 0; i < 8; i++) begin
            wr_cmd(junk, 8'hA0);
            wr_cmd(16'(i), pwd_val(i));
        end
        for (int i = 0; i < 8; i++) begin
            rd_at(AW'(i), v);
            chk($sformatf("R12 password byte %0d", i), v, pwd_val(i));
        end
        wr_cmd(junk, 8'hA0); wr_cmd(16'h0003, 8'h0F);
        rd_at(AW'(3), v);
        chk("R12 password and-write", v, pwd_val(3) & 8'h0F);
        leave_set();

        // R11: lock register, every data value from reset
        for (int d = 0; d < 256; d++) begin
            bit rej;
            do_reset();
            rej = (d & 6) == 0;
            enter_set(8'h40);
            wr_cmd(junk, 8'hA0); wr_cmd(junk, 8'(d));
            chk($sformatf("R11 mode after data %0h", d), rd_array, rej);
            if (!rej) begin
                rd_at('0, v);
                chk($sformatf("R11 value after data %0h", d), v, d);
            end else begin
                enter_set(8'h40);
                rd_at('0, v);
                chk("R11 rejected leaves FF", v, 8'hFF);
            end
        end
        do_reset();
        enter_set(8'h40);
        wr_cmd(junk, 8'hA0); wr_cmd(junk, 8'hF5);
        wr_cmd(junk, 8'hA0); wr_cmd(junk, 8'hFB);
        rd_at('0, v);
        chk("R11 bits only clear", v, 8'hF1);
        leave_set();
        chk("R7 reset clears dyn", prot_dyn, 8'h00);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule